// File: doc/BRIEF.md
# Multi-Line Receive Silo with Alarm

This block gathers characters from up to eight serial line receivers into one shared first-in first-out store (the silo). The host sees them as a single read port. Each stored word carries the character, the number of the line it came from, error flags and a valid bit. When the host pulses a read, the word at the head is returned and removed. A read that finds nothing returns an all-zero word.

Each receiver offers one character per handshake. The offer is a valid/ready pair with a byte, a break flag and a parity-error flag. In any cycle the block grants at most one line: the lowest-numbered line that is offering, has its receive enable set, and is seen while the master scan enable is on. A line keeps its offer steady until it sees ready. Ready does not depend on silo fill. A character granted while the silo is full is consumed and dropped, and the next stored entry records an overrun.

Two status flags are produced. Receive-done shows that data is waiting. The silo alarm is a one-shot threshold flag: it fires once when the fill reaches a set level, and it can only fire again after a host read has found the silo empty. A clear command empties the silo and re-arms the alarm.

Top module: `rx_silo_mux`

## Requirements
- R1: A returned word has the character in bits 7:0, the source line in bits 10:8, parity error in bit 12, framing error in bit 13, overrun in bit 14 and valid (1) in bit 15; bit 11 is 0.
- R2: A break offered by a line is stored with valid and framing error set, parity error clear and character field 0.
- R3: When several eligible lines offer in the same cycle, only the lowest-numbered one sees ln_ready; the others stay unready and are taken in later cycles.
- R4: Offers from a line whose rx_enable bit is 0, or any offer while scan_en is 0, are not granted and not stored.
- R5: rx_done is 1 exactly when scan_en is 1 and the silo holds at least one entry.
- R6: When the alarm is armed and the fill count reaches ALARM_LEVEL, silo_alarm rises on that same clock edge and the alarm disarms. It does not fire again while disarmed.
- R7: A host read clears silo_alarm. A read that returns an all-zero word re-arms the alarm.
- R8: A read while scan_en is 0 returns zero and removes nothing.
- R9: clr empties the silo, clears silo_alarm and any pending overrun, and re-arms the alarm.
- R10: A character granted while the silo is full and no read occurs is dropped, and the fill stays at DEPTH. The next entry that is stored has its overrun bit set.
- R11: A push and a pop in the same cycle are both honoured, and the fill count is unchanged.
- R12: Entries are returned in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_en | input | 1 | Master scan enable |
| clr | input | 1 | Clear command: empty the silo and re-arm the alarm |
| rx_enable | input | NLINES | Per-line receive enable |
| ln_valid | input | NLINES | Per-line character offer |
| ln_ready | output | NLINES | Per-line grant; at most one bit set |
| ln_char | input | NLINES*8 | Per-line character; line i uses bits 8i+7:8i |
| ln_break | input | NLINES | Per-line break indication |
| ln_perr | input | NLINES | Per-line parity error |
| rd_req | input | 1 | Host read strobe; rd_word is valid in the same cycle |
| rd_word | output | 16 | Head word, or zero if the silo is empty or scan is off |
| rx_done | output | 1 | Data waiting |
| silo_alarm | output | 1 | Threshold alarm flag |
| silo_count | output | $clog2(DEPTH+1) | Current fill |

## Verification
The bench builds the block with NLINES=8, ALARM_LEVEL=16 and DEPTH reduced to 20. With this depth the silo can be filled to the brim a few cycles after the alarm fires, so the full-drop and overrun-marking paths are reachable with short sequences. The alarm threshold stays at its normal value, so the one-shot fire, the disarm after a partial drain and the re-arm on an empty read are all exercised at the real level. Keeping all eight lines lets the lowest-line priority be checked between non-adjacent lines.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int CHAR_W = 8;
  localparam int LINE_W = 3;
  localparam int WORD_W = 16;

  typedef struct packed {
    logic              ovr;
    logic              ferr;
    logic              perr;
    logic [LINE_W-1:0] line;
    logic [CHAR_W-1:0] ch;
  } silo_entry_t;

  localparam int ENTRY_W = $bits(silo_entry_t);

  function automatic logic [WORD_W-1:0] to_word(silo_entry_t e);
    return {1'b1, e.ovr, e.ferr, e.perr, 1'b0, e.line, e.ch};
  endfunction
endpackage

// File: rtl/rxs_arbiter.sv
module rxs_arbiter #(
  parameter int NLINES = 8,
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] eligible,
  output logic [NLINES-1:0] grant,
  output logic              any,
  output logic [LW-1:0]     idx
);
  for (genvar g = 0; g < NLINES; g++) begin : g_gnt
    if (g == 0) begin : g_first
      assign grant[g] = eligible[0];
    end else begin : g_rest
      assign grant[g] = eligible[g] & ~(|eligible[g-1:0]);
    end
  end

  assign any = |eligible;

  always_comb begin
    idx = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (eligible[i]) idx = LW'(i);
    end
  end

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R3
  AST_IDX_MATCHES_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    any |-> grant[idx]); // R3
endmodule

// File: rtl/rxs_fifo.sv
module rxs_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 14,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  logic [W-1:0]  din,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_next,
  output logic          empty,
  output logic          full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          wr, rd;

  assign empty = (count == '0);
  assign full  = (count == CW'(DEPTH));
  assign rd    = pop && !empty;
  assign wr    = push && (!full || rd);
  assign dout  = mem[rptr];

  function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_comb begin
    if (clr)            count_next = '0;
    else if (wr && !rd) count_next = count + CW'(1);
    else if (rd && !wr) count_next = count - CW'(1);
    else                count_next = count;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr) wptr <= bump(wptr);
      if (rd) rptr <= bump(rptr);
      count <= count_next;
    end
  end

  always_ff @(posedge clk) begin
    if (wr) mem[wptr] <= din;
  end

  AST_PUSH_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop && !clr) |=> (count == $past(count) + CW'(1))); // R10
  AST_PUSH_POP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && !empty && !clr) |=> $stable(count)); // R11
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty); // R9
endmodule

// File: rtl/rxs_alarm.sv
module rxs_alarm #(
  parameter int CW    = 7,
  parameter int LEVEL = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          rd_req,
  input  logic          rd_zero,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] count_next,
  output logic          alarm,
  output logic          armed
);
  logic fire;
  assign fire = armed && !clr && (count_next >= CW'(LEVEL));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      alarm <= 1'b0;
      armed <= 1'b1;
    end else begin
      if (fire)        alarm <= 1'b1;
      else if (rd_req) alarm <= 1'b0;
      if (rd_req && rd_zero) armed <= 1'b1;
      else if (fire)         armed <= 1'b0;
    end
  end

  AST_ALARM_AT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> (count >= CW'(LEVEL))); // R6
  AST_ALARM_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> !armed); // R6
endmodule

// File: rtl/rx_silo_mux.sv
module rx_silo_mux
  import rxs_pkg::*;
#(
  parameter int NLINES      = 8,
  parameter int DEPTH       = 64,
  parameter int ALARM_LEVEL = 16,
  localparam int LW = (NLINES > 1) ? $clog2(NLINES) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scan_en,
  input  logic                     clr,
  input  logic [NLINES-1:0]        rx_enable,
  input  logic [NLINES-1:0]        ln_valid,
  output logic [NLINES-1:0]        ln_ready,
  input  logic [NLINES*CHAR_W-1:0] ln_char,
  input  logic [NLINES-1:0]        ln_break,
  input  logic [NLINES-1:0]        ln_perr,
  input  logic                     rd_req,
  output logic [WORD_W-1:0]        rd_word,
  output logic                     rx_done,
  output logic                     silo_alarm,
  output logic [CW-1:0]            silo_count
);
  logic [NLINES-1:0] eligible, grant;
  logic              any;
  logic [LW-1:0]     idx;
  silo_entry_t       in_e, head_e;
  logic [CW-1:0]     count_next;
  logic              empty, full, pop, stored, ovr_pend, armed;

  assign eligible = ln_valid & rx_enable & {NLINES{scan_en && !clr}};

  rxs_arbiter #(.NLINES(NLINES)) u_arb (
    .clk(clk), .rst_n(rst_n), .eligible(eligible),
    .grant(grant), .any(any), .idx(idx)
  );
  assign ln_ready = grant;

  always_comb begin
    in_e.ferr = ln_break[idx];
    in_e.perr = ln_perr[idx] & ~ln_break[idx];
    in_e.ovr  = ovr_pend;
    in_e.line = LINE_W'(idx);
    in_e.ch   = ln_break[idx] ? '0 : ln_char[idx*CHAR_W +: CHAR_W];
  end

  assign pop    = rd_req && scan_en && !empty;
  assign stored = any && (!full || pop);

  rxs_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .push(any), .pop(pop), .din(in_e), .dout(head_e),
    .count(silo_count), .count_next(count_next),
    .empty(empty), .full(full)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || clr)   ovr_pend <= 1'b0;
    else if (stored)     ovr_pend <= 1'b0;
    else if (any && full) ovr_pend <= 1'b1;
  end

  assign rx_done = scan_en && !empty;
  assign rd_word = rx_done ? to_word(head_e) : '0;

  rxs_alarm #(.CW(CW), .LEVEL(ALARM_LEVEL)) u_alarm (
    .clk(clk), .rst_n(rst_n), .clr(clr), .rd_req(rd_req),
    .rd_zero(rd_word == '0), .count(silo_count), .count_next(count_next),
    .alarm(silo_alarm), .armed(armed)
  );

  AST_SCAN_OFF_NO_POP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !scan_en && !clr) |=> $stable(silo_count)); // R8
  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (any && full && !rd_req && !clr) |=> (silo_count == CW'(DEPTH))); // R10
  AST_READ_CLEARS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !clr && count_next < CW'(ALARM_LEVEL)) |=> !silo_alarm); // R7
endmodule

// File: tb/tb_rx_silo_mux.sv
module tb_rx_silo_mux;
  localparam int NL = 8;
  localparam int DP = 20;
  localparam int AL = 16;
  localparam int CW = $clog2(DP + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scan_en = 1'b0, clr = 1'b0, rd_req = 1'b0;
  logic [NL-1:0] rx_enable = '0, ln_valid = '0, ln_break = '0, ln_perr = '0;
  logic [NL-1:0] ln_ready;
  logic [NL*8-1:0] ln_char = '0;
  logic [15:0]   rd_word;
  logic          rx_done, silo_alarm;
  logic [CW-1:0] silo_count;

  int n_checks = 0, n_fail = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  rx_silo_mux #(.NLINES(NL), .DEPTH(DP), .ALARM_LEVEL(AL)) dut (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .clr(clr),
    .rx_enable(rx_enable), .ln_valid(ln_valid), .ln_ready(ln_ready),
    .ln_char(ln_char), .ln_break(ln_break), .ln_perr(ln_perr),
    .rd_req(rd_req), .rd_word(rd_word), .rx_done(rx_done),
    .silo_alarm(silo_alarm), .silo_count(silo_count)
  );

  // [31:29] line, [28] break, [27] parity error, [23:16] char, [15:0] expected word
  localparam logic [31:0] VECS [6] = '{
    32'h0041_8041, 32'h60FF_83FF, 32'hE000_8700,
    32'hB055_A500, 32'h487E_927E, 32'hC080_8680
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic push(input int l, input logic [7:0] ch, input logic brk, input logic pe);
    @(negedge clk);
    ln_valid[l] = 1'b1; ln_char[l*8 +: 8] = ch; ln_break[l] = brk; ln_perr[l] = pe;
    @(negedge clk);
    ln_valid[l] = 1'b0; ln_break[l] = 1'b0; ln_perr[l] = 1'b0;
  endtask

  task automatic read(output logic [15:0] w);
    @(negedge clk);
    rd_req = 1'b1;
    #1 w = rd_word;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] w;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(rx_done, 0, "R5 reset done");
    check(silo_alarm, 0, "R7 reset alarm");
    check(silo_count, 0, "R9 reset count");
    check(rd_word, 0, "R8 reset word");
    scan_en = 1'b1; rx_enable = '1;

    for (int v = 0; v < 6; v++) begin
      push(int'(VECS[v][31:29]), VECS[v][23:16], VECS[v][28], VECS[v][27]);
      check(rx_done, 1, "R5 done after push");
      read(w);
      check(w, VECS[v][15:0], (VECS[v][28]) ? "R2 break word" : "R1 word layout");
      check(silo_count, 0, "R12 drained");
    end

    // R3 priority between lines 2 and 5
    @(negedge clk);
    ln_valid = 8'b0010_0100; ln_char[2*8 +: 8] = 8'h22; ln_char[5*8 +: 8] = 8'h55;
    #1 check(ln_ready, 8'b0000_0100, "R3 lowest granted");
    @(negedge clk);
    ln_valid[2] = 1'b0;
    #1 check(ln_ready, 8'b0010_0000, "R3 next granted");
    @(negedge clk);
    ln_valid = '0;
    read(w); check(w, 16'h8222, "R12 first line 2");
    read(w); check(w, 16'h8555, "R12 then line 5");

    // R4 disabled line and scan off
    rx_enable[4] = 1'b0;
    push(4, 8'h44, 0, 0);
    check(silo_count, 0, "R4 disabled line ignored");
    check(rd_word, 0, "R4 nothing to read");
    rx_enable[4] = 1'b1;
    scan_en = 1'b0;
    push(1, 8'h01, 0, 0);
    scan_en = 1'b1; #1;
    check(silo_count, 0, "R4 scan off ignored");

    // R8 read with scan off
    push(1, 8'h11, 0, 0);
    scan_en = 1'b0; #1;
    check(rx_done, 0, "R5 done needs scan");
    read(w);
    check(w, 0, "R8 scan off word");
    check(silo_count, 1, "R8 no pop");
    scan_en = 1'b1;
    read(w); check(w, 16'h8111, "R8 entry kept");

    // R6 alarm fires at level
    for (int k = 0; k < AL; k++) begin
      push(0, 8'(k), 0, 0);
      if (k == AL - 2) check(silo_alarm, 0, "R6 below level");
    end
    check(silo_alarm, 1, "R6 fires at level");
    read(w); check(w, 16'h8000, "R12 head first");
    check(silo_alarm, 0, "R7 read clears alarm");
    push(3, 8'h33, 0, 0);
    check(silo_count, AL, "R6 back at level");
    check(silo_alarm, 0, "R6 disarmed one shot");
    for (int k = 0; k < AL; k++) read(w);
    check(w, 16'h8333, "R12 last out");
    read(w); check(w, 0, "R7 empty read");
    for (int k = 0; k < AL; k++) push(0, 8'h00, 0, 0);
    check(silo_alarm, 1, "R7 rearmed by empty read");

    // R9 clear
    pulse_clr(); #1;
    check(silo_count, 0, "R9 clear empties");
    check(silo_alarm, 0, "R9 clear drops alarm");
    check(rx_done, 0, "R9 done after clear");
    for (int k = 0; k < AL; k++) push(0, 8'h00, 0, 0);
    check(silo_alarm, 1, "R9 clear rearms");

    // R10 overrun
    pulse_clr();
    for (int k = 0; k < DP; k++) push(0, 8'(k), 0, 0);
    check(silo_count, DP, "R10 full");
    push(1, 8'hEE, 0, 0);
    check(silo_count, DP, "R10 dropped when full");
    read(w); check(w, 16'h8000, "R10 head");
    push(2, 8'h33, 0, 0);
    check(silo_count, DP, "R10 refilled");
    for (int k = 1; k < DP; k++) read(w);
    check(w, 16'h8013, "R10 older entries intact");
    read(w); check(w, 16'hC233, "R10 overrun marked");

    // R11 push and pop together
    pulse_clr();
    for (int k = 0; k < 3; k++) push(0, 8'(k), 0, 0);
    @(negedge clk);
    ln_valid[6] = 1'b1; ln_char[6*8 +: 8] = 8'h66; rd_req = 1'b1;
    @(negedge clk);
    ln_valid[6] = 1'b0; rd_req = 1'b0;
    #1 check(silo_count, 3, "R11 count steady");
    read(w); check(w, 16'h8001, "R11 pop took head");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule